// File: doc/BRIEF.md
# SPI Boot Memory Stream Reader

This block is an SPI master that pulls a boot image out of an external serial EEPROM or serial flash. A single-cycle start pulse latches the start address, the address width selection and a byte-count limit. Chip select is then driven low for the whole transaction. The block shifts out the read opcode and the address, then keeps clocking so the memory streams consecutive bytes back. Each received byte is offered on a valid/ready output.

The serial clock comes from a divider on the system clock and idles low (SPI mode 0). When the consumer is not ready, the serial clock pauses between bytes, so nothing is dropped. The transfer ends at the byte-count limit or at the byte boundary that follows a stop request. One serial-clock period later chip select is released and busy falls.

Top module: `spi_boot_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, valid_o is 0 and busy_o is 0.
- R2: The first byte shifted out after cs_n_o falls is the read opcode 0x03, sent MSB first.
- R3: The opcode is followed by address bytes taken from the low bits of start_addr_i, most significant byte first and each byte MSB first. addr_mode_i = 1 selects one byte, 2 selects two bytes, and 0 or 3 select three bytes.
- R4: SCK idles low and each half period lasts HALF_DIV clock cycles. MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R5: In the data phase MOSI stays 0. No further opcode is sent. Every eight SCK pulses deliver one byte on data_o (first bit received is bit 7), in increasing memory address order.
- R6: While valid_o is high and ready_i is low, valid_o and data_o hold their values. SCK does not start the next data byte until the output slot is free, so no byte is lost.
- R7: A nonzero byte_limit_i ends the transfer after exactly that many bytes. A value of zero places no limit.
- R8: A stop_i pulse ends the transfer at the next byte boundary. A byte already being shifted is completed and delivered. A stop during the header ends the transfer with no data byte.
- R9: cs_n_o rises between 2*HALF_DIV and 2*HALF_DIV+1 clock cycles after the last falling edge of SCK. busy_o falls in the same cycle.
- R10: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a transfer when idle |
| stop_i | input | 1 | Pulse that ends the transfer at the next byte boundary |
| addr_mode_i | input | 2 | Address byte count selection (1, 2, or 0/3 for three) |
| start_addr_i | input | 24 | First memory address to read |
| byte_limit_i | input | CNT_W | Bytes to read, 0 for no limit |
| sck_o | output | 1 | Serial clock to memory |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to memory |
| miso_i | input | 1 | Serial data from memory |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | data_o holds a byte |
| ready_i | input | 1 | Consumer takes the byte |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench sweeps all four address-mode codes, each with three consumer patterns: always ready, ready on alternate cycles, and ready once in nine cycles. The first pattern shows that the stream runs back to back. The stalled patterns show that SCK pauses instead of dropping or repeating bytes. Memory contents are an arithmetic function of the address, so a wrong address width, wrong byte order or a skipped byte shows up as a data mismatch. Separate runs stop in the header, stop mid-stream with no limit, use a long limit, and pulse start again during a transfer. These tell the stop, limit and ignore-start paths apart.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_DELIVER,
    ST_HOLD
  } rdr_state_t;

  localparam logic [7:0] READ_OPCODE = 8'h03;

  // Number of address bytes for a mode code: 1 -> 1, 2 -> 2, else 3.
  function automatic logic [1:0] addr_byte_count(input logic [1:0] mode);
    case (mode)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Header byte at position idx: 0 is the opcode, 1..n are address bytes, MSB first.
  function automatic logic [7:0] header_byte(input logic [1:0]  idx,
                                             input logic [23:0] addr,
                                             input logic [1:0]  nbytes);
    logic [1:0]  k;
    logic [23:0] sh;
    if (idx == 2'd0) return READ_OPCODE;
    k  = nbytes - idx;
    sh = addr >> {k, 3'b000};
    return sh[7:0];
  endfunction

endpackage

// File: rtl/sbr_tick.sv
module sbr_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sbr_shreg.sv
module sbr_shreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic       sample,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx
);
  logic [7:0] tx;

  assign mosi = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load)       tx <= load_val;
      else if (shift) tx <= {tx[6:0], 1'b0};
      if (sample)     rx <= {rx[6:0], miso};
    end
  end
endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader
  import spi_boot_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       addr_mode_i,
  input  logic [23:0]      start_addr_i,
  input  logic [CNT_W-1:0] byte_limit_i,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             busy_o
);

  rdr_state_t       state;
  logic [1:0]       mode_q;
  logic [23:0]      addr_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] out_cnt;
  logic [3:0]       bit_cnt;
  logic [1:0]       hdr_idx;
  logic             data_phase;
  logic             stop_req;
  logic             sck_q;
  logic             valid_q;
  logic [7:0]       data_q;

  // named internal events
  logic       div_en, tick;
  logic       start_ok, sck_rise, sck_fall, byte_end, hdr_last;
  logic       accept, limit_hit, stop_now;
  logic       sr_load, sr_shift;
  logic [7:0] sr_val, rx_byte;
  logic [1:0] n_addr;

  assign n_addr    = addr_byte_count(mode_q);
  assign div_en    = (state == ST_SETUP) || (state == ST_XFER) || (state == ST_HOLD);
  assign start_ok  = (state == ST_IDLE) && start_i;
  assign sck_rise  = (state == ST_XFER) && tick && !sck_q;
  assign sck_fall  = (state == ST_XFER) && tick && sck_q;
  assign byte_end  = sck_fall && (bit_cnt == 4'd8);
  assign hdr_last  = (hdr_idx == n_addr);
  assign accept    = (state == ST_DELIVER) && (!valid_q || ready_i);
  assign limit_hit = (limit_q != '0) && ((out_cnt + CNT_W'(1)) == limit_q);
  assign stop_now  = stop_req || stop_i;

  assign sr_load  = start_ok || (byte_end && !data_phase);
  assign sr_val   = start_ok ? READ_OPCODE :
                    (hdr_last ? 8'h00 : header_byte(hdr_idx + 2'd1, addr_q, n_addr));
  assign sr_shift = sck_fall && (bit_cnt != 4'd8);

  sbr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (div_en),
    .tick  (tick)
  );

  sbr_shreg u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sr_load),
    .load_val (sr_val),
    .shift    (sr_shift),
    .sample   (sck_rise),
    .miso     (miso_i),
    .mosi     (mosi_o),
    .rx       (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= '0;
      addr_q     <= '0;
      limit_q    <= '0;
      out_cnt    <= '0;
      bit_cnt    <= '0;
      hdr_idx    <= '0;
      data_phase <= 1'b0;
      sck_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sck_q <= 1'b0;
          if (start_i) begin
            state      <= ST_SETUP;
            mode_q     <= addr_mode_i;
            addr_q     <= start_addr_i;
            limit_q    <= byte_limit_i;
            out_cnt    <= '0;
            bit_cnt    <= '0;
            hdr_idx    <= '0;
            data_phase <= 1'b0;
          end
        end
        ST_SETUP: if (tick) state <= ST_XFER;
        ST_XFER: begin
          if (sck_rise) begin
            sck_q   <= 1'b1;
            bit_cnt <= bit_cnt + 4'd1;
          end else if (sck_fall) begin
            sck_q <= 1'b0;
            if (byte_end) begin
              bit_cnt <= '0;
              if (!data_phase) begin
                if (hdr_last) data_phase <= 1'b1;
                else          hdr_idx    <= hdr_idx + 2'd1;
                if (stop_now) state <= ST_HOLD;
              end else begin
                state <= ST_DELIVER;
              end
            end
          end
        end
        ST_DELIVER: if (accept) begin
          out_cnt <= out_cnt + CNT_W'(1);
          state   <= (stop_now || limit_hit) ? ST_HOLD : ST_XFER;
        end
        ST_HOLD: if (tick) begin
          if (bit_cnt == 4'd1) state   <= ST_IDLE;
          else                 bit_cnt <= bit_cnt + 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stop_req <= 1'b0;
    else if (state == ST_IDLE) stop_req <= 1'b0;
    else if (stop_i)           stop_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= rx_byte;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign sck_o   = sck_q;
  assign cs_n_o  = (state == ST_IDLE);
  assign busy_o  = (state != ST_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       valid_o,
  input logic       ready_i,
  input logic [7:0] data_o,
  input logic       busy_o,
  input logic       data_phase,
  input logic       sck_rise,
  input logic       sck_fall
);

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> (sck_o && !sck_fall));

  assert_data_mosi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && data_phase) |-> !mosi_o);

  assert_hold_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (!busy_o && !sck_o));

endmodule

bind spi_boot_reader sbr_checker u_sbr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_o     (cs_n_o),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .data_o     (data_o),
  .busy_o     (busy_o),
  .data_phase (data_phase),
  .sck_rise   (sck_rise),
  .sck_fall   (sck_fall)
);

// File: tb/tb_spi_boot_reader.sv
`timescale 1ns/1ps
module tb_spi_boot_reader;
  localparam int H     = 2;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [1:0]       addr_mode_i = '0;
  logic [23:0]      start_addr_i = '0;
  logic [CNT_W-1:0] byte_limit_i = '0;
  logic             sck_o, cs_n_o, mosi_o;
  logic             miso_i = 1'b0;
  logic [7:0]       data_o;
  logic             valid_o;
  logic             ready_i = 1'b1;
  logic             busy_o;

  always #2 clk = ~clk;  // 250 MHz

  spi_boot_reader #(.HALF_DIV(H), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_mode_i(addr_mode_i), .start_addr_i(start_addr_i),
    .byte_limit_i(byte_limit_i), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .data_o(data_o), .valid_o(valid_o),
    .ready_i(ready_i), .busy_o(busy_o)
  );

  int nchecks = 0;
  int nerrors = 0;

  // memory model contents
  function automatic logic [7:0] memf(input logic [23:0] a);
    return (a[7:0] * 8'd29 + a[15:8]) ^ a[23:16] ^ 8'hA5;
  endfunction

  // model / monitor state
  int          cyc = 0;
  int          rmode = 0;
  int          stop_at = -1;
  bit          stop_sent = 0;
  int          n_hdr = 3;
  int          rises, mosi_err, hi_err, half_err, stable_err, csfall;
  int          rise_t, last_fall, gap;
  bit          cs_rise_seen, busy_at_rise;
  logic [7:0]  cmd;
  logic [23:0] addr_cap;
  logic [7:0]  got [0:63];
  int          ngot;
  logic        cs_prev = 1'b1, sck_prev = 1'b0, mosi_prev = 1'b0;
  logic        vprev = 1'b0, rprev = 1'b0;
  logic [7:0]  dprev = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerrors++; nchecks++;
      $display("FAIL watchdog: run did not end actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
    // consumer
    case (rmode)
      0: ready_i = 1'b1;
      1: ready_i = cyc[0];
      default: ready_i = (cyc % 9 == 0);
    endcase
    if (valid_o && ready_i && ngot < 64) begin
      got[ngot] = data_o;
      ngot++;
    end
    if (!stop_sent && ((stop_at > 0 && ngot == stop_at) || (stop_at == 0 && csfall > 0))) begin
      stop_i = 1'b1; stop_sent = 1;
    end else stop_i = 1'b0;
    // hold check for R6
    if (vprev && !rprev && (!valid_o || data_o != dprev)) stable_err++;
    vprev = valid_o; rprev = ready_i; dprev = data_o;
    // chip select
    if (!cs_n_o && cs_prev) csfall++;
    if (cs_n_o && !cs_prev) begin
      cs_rise_seen = 1; gap = cyc - last_fall; busy_at_rise = busy_o;
    end
    // SPI memory model
    if (!cs_n_o) begin
      if (sck_o && !sck_prev) begin
        rise_t = cyc;
        if (rises < 8) cmd = {cmd[6:0], mosi_o};
        else if (rises < 8 * (1 + n_hdr)) addr_cap = {addr_cap[22:0], mosi_o};
        else if (mosi_o) mosi_err++;
        rises++;
      end
      if (!sck_o && sck_prev) begin
        if (cyc - rise_t != H) half_err++;
        last_fall = cyc;
        if (rises >= 8 * (1 + n_hdr)) begin
          automatic int k = rises - 8 * (1 + n_hdr);
          automatic logic [7:0] b = memf(addr_cap + 24'(k / 8));
          miso_i = b[7 - (k % 8)];
        end
      end
      if (sck_o && sck_prev && mosi_o != mosi_prev) hi_err++;
    end
    cs_prev = cs_n_o; sck_prev = sck_o; mosi_prev = mosi_o;
  end

  task automatic run_case(input logic [1:0] mode, input logic [23:0] addr,
                          input int limit, input int rm, input int stp,
                          input bit restart);
    int nexp, bad, first_bad;
    logic [23:0] mask, a0;
    n_hdr = (mode == 2'd1) ? 1 : (mode == 2'd2) ? 2 : 3;
    mask  = (n_hdr == 1) ? 24'h0000FF : (n_hdr == 2) ? 24'h00FFFF : 24'hFFFFFF;
    @(negedge clk);
    rmode = rm; stop_at = stp; stop_sent = 0;
    rises = 0; mosi_err = 0; hi_err = 0; half_err = 0; stable_err = 0;
    csfall = 0; cs_rise_seen = 0; busy_at_rise = 1; gap = 0;
    cmd = '0; addr_cap = '0; ngot = 0; rise_t = cyc; last_fall = cyc;
    addr_mode_i = mode; start_addr_i = addr; byte_limit_i = CNT_W'(limit);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (restart) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; start_addr_i = 24'h00_0000;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 5000 && !cs_rise_seen; t++) @(negedge clk);
    for (int t = 0; t < 60 && valid_o; t++) @(negedge clk);
    @(negedge clk);
    nexp = (stp < 0) ? limit : (stp == 0) ? 0 : stp + 1;
    a0   = addr & mask;
    check(cs_rise_seen, "R9", "transfer ended", cs_rise_seen, 1);
    check(cmd == 8'h03, "R2", "read opcode", cmd, 8'h03);
    if (stp != 0)
      check(addr_cap == a0, "R3", "address bytes", addr_cap, a0);
    check(rises == 8 * ((stp == 0) ? 1 : (1 + n_hdr + nexp)), "R5",
          "SCK pulse count", rises, 8 * ((stp == 0) ? 1 : (1 + n_hdr + nexp)));
    check(ngot == nexp, (stp < 0) ? "R7" : "R8", "bytes delivered", ngot, nexp);
    bad = 0; first_bad = -1;
    for (int i = 0; i < ngot && i < 64; i++)
      if (got[i] != memf(a0 + 24'(i))) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    check(bad == 0, "R5", "stream byte",
          (first_bad < 0) ? 0 : got[first_bad],
          (first_bad < 0) ? 0 : memf(a0 + 24'(first_bad)));
    check(mosi_err == 0, "R5", "MOSI high in data phase", mosi_err, 0);
    check(hi_err == 0 && half_err == 0, "R4", "SCK timing / MOSI edge", hi_err + half_err, 0);
    check(stable_err == 0, "R6", "output held while stalled", stable_err, 0);
    check(gap >= 2 * H && gap <= 2 * H + 1, "R9", "chip select release delay", gap, 2 * H);
    check(!busy_at_rise, "R9", "busy with chip select", busy_at_rise, 0);
    check(csfall == 1, "R10", "single chip select assertion", csfall, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n_o && !sck_o && !valid_o && !busy_o, "R1", "reset outputs",
          {cs_n_o, sck_o, valid_o, busy_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n_o && !busy_o, "R1", "idle after reset", {cs_n_o, busy_o}, 2'b10);
    // sweep address modes against consumer patterns (R3, R5, R6, R7)
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 3; r++)
        run_case(2'(m), 24'hA1B2C3 ^ 24'(m * 24'h030507), 1 + ((m + r) % 4) + r, r, -1, 0);
    run_case(2'd2, 24'h00F010, 20, 0, -1, 0);   // long limit, R7
    run_case(2'd1, 24'h000040, 1, 2, -1, 0);    // single byte, R7
    run_case(2'd1, 24'h123456, 0, 0, 3, 0);     // R8 stop mid-stream, no limit
    run_case(2'd3, 24'h7E0011, 0, 0, 1, 0);     // R8 stop after first byte
    run_case(2'd0, 24'h445566, 0, 0, 0, 0);     // R8 stop in header
    run_case(2'd3, 24'h010203, 6, 0, -1, 1);    // R10 start while busy
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule